// File: doc/BRIEF.md
# Processor Status Register with Write Arbitration

This block holds the 8-bit status word of a small processor core and decides, on every clock, which of three sources sets each bit. Software stores reach it through a write strobe with data. The arithmetic unit reports zero, digit-carry and carry results together with a mask that says which of those flags the current instruction changes. Power-management events move the two power-status bits: power-on reset, watchdog clear, entry to sleep and watchdog expiry. The result is a single registered status word.

The time-out and power-down bits are kept by a small state machine with four named states, encoded as {time-out, power-down}. PWR_FRESH (11) is entered on power-on reset or watchdog clear. PWR_ASLEEP (10) is entered on sleep. PWR_WDOG_RUN (01) is reached from PWR_FRESH on watchdog expiry. PWR_WDOG_SLEEP (00) is reached from PWR_ASLEEP on watchdog expiry. Expiry in either watchdog state stays in that state. Expiry takes priority over sleep, and sleep takes priority over watchdog clear. Software writes never touch these two bits.

When an instruction that changes any arithmetic flag also names this register as its destination, the data write to all three flag bits is dropped. The flags named in the mask take the arithmetic values, and the other flags keep their old values. Clearing the register with an instruction therefore leaves the power bits, DC and C untouched.

Top module: `sreg_arbiter`

## Requirements
- R1: status_o carries, from bit 7 down to bit 0: bank select bits [7:5], time-out [4], power-down [3], Z [2], DC [1], C [0]. Each update shows on status_o one clock edge after its inputs are sampled.
- R2: A cycle with por_i high sets status_o to 8'b000_11_000 on the next edge, and this overrides every other input in that cycle.
- R3: Data writes never change bits [4:3]. This also holds when a write arrives in the same cycle as a power event.
- R4: A sleep_i pulse with wdt_to_i low sets time-out to 1 and power-down to 0 (state PWR_ASLEEP).
- R5: A wdt_clr_i pulse with sleep_i and wdt_to_i low sets both time-out and power-down to 1 (state PWR_FRESH).
- R6: A wdt_to_i pulse clears time-out and keeps power-down. It takes priority over sleep_i and wdt_clr_i in the same cycle.
- R7: Each flag whose bit in flag_aff_i is set (bit 2 = Z, bit 1 = DC, bit 0 = C) takes the matching flag_val_i bit, whether or not a write is present.
- R8: A write with flag_aff_i == 0 loads bits [2:0] from wr_data_i. A write with any mask bit set leaves the unmasked flags unchanged.
- R9: Bits [7:5] take wr_data_i[7:5] on a write and hold otherwise.
- R10: With no write and a zero mask, bits [2:0] hold.
- R11: A clear instruction (write of 0 with only Z affected and Z value 1) leaves bits [7:5] at 0, Z at 1, and time-out, power-down, DC and C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Synchronous power-on reset, active high |
| wr_en_i | input | 1 | Data write strobe for the register address |
| wr_data_i | input | 8 | Data write value |
| flag_aff_i | input | 3 | Flags changed by the current instruction {Z,DC,C} |
| flag_val_i | input | 3 | Flag values from the arithmetic unit {Z,DC,C} |
| wdt_clr_i | input | 1 | Watchdog clear event |
| sleep_i | input | 1 | Sleep entry event |
| wdt_to_i | input | 1 | Watchdog expiry event |
| status_o | output | 8 | Current register value |

## Verification
The properties assume that por_i is high at the first clock edge and that every input is a known 0 or 1 outside reset. Under those assumptions, one-edge relations between sampled inputs and status_o are well defined. The stimulus drives every input to a defined level from time zero and holds power-on reset for two cycles. It changes inputs only on falling clock edges, so collisions between writes, flag updates and events are seen exactly as intended. Several events may be raised in the same cycle, because the priority order defines the result for every combination.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int BANK_W = 3;
    localparam int FLAG_W = 3;

    // Encoded as {time-out, power-down}
    typedef enum logic [1:0] {
        PWR_WDOG_SLEEP = 2'b00,
        PWR_WDOG_RUN   = 2'b01,
        PWR_ASLEEP     = 2'b10,
        PWR_FRESH      = 2'b11
    } pwr_state_e;
endpackage

// File: rtl/sreg_pwr_fsm.sv
module sreg_pwr_fsm
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic por_i,
    input  logic wdt_clr_i,
    input  logic sleep_i,
    input  logic wdt_to_i,
    output logic to_o,
    output logic pd_o
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wdt_to_i) begin
            unique case (state_q)
                PWR_FRESH:      state_d = PWR_WDOG_RUN;
                PWR_ASLEEP:     state_d = PWR_WDOG_SLEEP;
                PWR_WDOG_RUN:   state_d = PWR_WDOG_RUN;
                PWR_WDOG_SLEEP: state_d = PWR_WDOG_SLEEP;
                default:        state_d = PWR_FRESH;
            endcase
        end else if (sleep_i) begin
            state_d = PWR_ASLEEP;
        end else if (wdt_clr_i) begin
            state_d = PWR_FRESH;
        end
    end

    always_ff @(posedge clk) begin
        if (por_i) state_q <= PWR_FRESH;
        else       state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PWR_FRESH:      begin to_o = 1'b1; pd_o = 1'b1; end
            PWR_ASLEEP:     begin to_o = 1'b1; pd_o = 1'b0; end
            PWR_WDOG_RUN:   begin to_o = 1'b0; pd_o = 1'b1; end
            PWR_WDOG_SLEEP: begin to_o = 1'b0; pd_o = 1'b0; end
            default:        begin to_o = 1'b1; pd_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/sreg_field_reg.sv
module sreg_field_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (por_i)     q_o <= '0;
        else if (ld_i) q_o <= d_i;
    end
endmodule

// File: rtl/sreg_flag_merge.sv
module sreg_flag_merge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] flag_aff_i,
    input  logic [W-1:0] flag_val_i,
    output logic [W-1:0] flags_o
);
    logic         data_ok;
    logic [W-1:0] flags_d;

    // Any flag-changing instruction blocks the data path for all flags
    assign data_ok = wr_en_i && (flag_aff_i == '0);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (flag_aff_i[i])  flags_d[i] = flag_val_i[i];
            else if (data_ok)   flags_d[i] = wr_data_i[i];
            else                flags_d[i] = flags_o[i];
        end
    end

    always_ff @(posedge clk) begin
        if (por_i) flags_o <= '0;
        else       flags_o <= flags_d;
    end
endmodule

// File: rtl/sreg_arbiter.sv
module sreg_arbiter #(
    parameter int BANK_W = sreg_pkg::BANK_W,
    parameter int FLAG_W = sreg_pkg::FLAG_W,
    localparam int REG_W = BANK_W + 2 + FLAG_W
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [FLAG_W-1:0] flag_aff_i,
    input  logic [FLAG_W-1:0] flag_val_i,
    input  logic              wdt_clr_i,
    input  logic              sleep_i,
    input  logic              wdt_to_i,
    output logic [REG_W-1:0]  status_o
);
    logic              to_bit, pd_bit;
    logic [BANK_W-1:0] bank_q;
    logic [FLAG_W-1:0] flag_q;

    sreg_pwr_fsm u_pwr (
        .clk       (clk),
        .por_i     (por_i),
        .wdt_clr_i (wdt_clr_i),
        .sleep_i   (sleep_i),
        .wdt_to_i  (wdt_to_i),
        .to_o      (to_bit),
        .pd_o      (pd_bit)
    );

    sreg_field_reg #(.W(BANK_W)) u_bank (
        .clk   (clk),
        .por_i (por_i),
        .ld_i  (wr_en_i),
        .d_i   (wr_data_i[REG_W-1 -: BANK_W]),
        .q_o   (bank_q)
    );

    sreg_flag_merge #(.W(FLAG_W)) u_flags (
        .clk        (clk),
        .por_i      (por_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i[FLAG_W-1:0]),
        .flag_aff_i (flag_aff_i),
        .flag_val_i (flag_val_i),
        .flags_o    (flag_q)
    );

    assign status_o = {bank_q, to_bit, pd_bit, flag_q};
endmodule

// File: rtl/sreg_arbiter_chk.sv
module sreg_arbiter_chk #(
    parameter int BANK_W = 3,
    parameter int FLAG_W = 3,
    localparam int REG_W = BANK_W + 2 + FLAG_W,
    localparam int TO_IX = FLAG_W + 1,
    localparam int PD_IX = FLAG_W
) (
    input logic              clk,
    input logic              por_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [FLAG_W-1:0] flag_aff_i,
    input logic [FLAG_W-1:0] flag_val_i,
    input logic              wdt_clr_i,
    input logic              sleep_i,
    input logic              wdt_to_i,
    input logic [REG_W-1:0]  status_o
);
    logic ev_any;
    assign ev_any = wdt_clr_i | sleep_i | wdt_to_i;

    a_r2_por_state: assert property (@(posedge clk)
        por_i |=> status_o == {{BANK_W{1'b0}}, 2'b11, {FLAG_W{1'b0}}});

    a_r3_pwr_hold: assert property (@(posedge clk) disable iff (por_i)
        !ev_any |=> $stable(status_o[TO_IX:PD_IX]));

    a_r4_sleep: assert property (@(posedge clk) disable iff (por_i)
        (sleep_i && !wdt_to_i) |=> status_o[TO_IX:PD_IX] == 2'b10);

    a_r5_wdt_clear: assert property (@(posedge clk) disable iff (por_i)
        (wdt_clr_i && !sleep_i && !wdt_to_i) |=> status_o[TO_IX:PD_IX] == 2'b11);

    a_r6_timeout: assert property (@(posedge clk) disable iff (por_i)
        wdt_to_i |=> (!status_o[TO_IX] && status_o[PD_IX] == $past(status_o[PD_IX])));

    a_r7_flag_wins: assert property (@(posedge clk) disable iff (por_i)
        (flag_aff_i != '0) |=>
            ((status_o[FLAG_W-1:0] & $past(flag_aff_i)) == ($past(flag_val_i) & $past(flag_aff_i))));

    a_r8_data_flags: assert property (@(posedge clk) disable iff (por_i)
        (wr_en_i && flag_aff_i == '0) |=> status_o[FLAG_W-1:0] == $past(wr_data_i[FLAG_W-1:0]));

    a_r8_blocked_hold: assert property (@(posedge clk) disable iff (por_i)
        (wr_en_i && flag_aff_i != '0) |=>
            ((status_o[FLAG_W-1:0] & ~$past(flag_aff_i)) == ($past(status_o[FLAG_W-1:0]) & ~$past(flag_aff_i))));

    a_r9_bank_load: assert property (@(posedge clk) disable iff (por_i)
        wr_en_i |=> status_o[REG_W-1 -: BANK_W] == $past(wr_data_i[REG_W-1 -: BANK_W]));

    a_r9_bank_hold: assert property (@(posedge clk) disable iff (por_i)
        !wr_en_i |=> $stable(status_o[REG_W-1 -: BANK_W]));

    a_r10_flag_hold: assert property (@(posedge clk) disable iff (por_i)
        (!wr_en_i && flag_aff_i == '0) |=> $stable(status_o[FLAG_W-1:0]));
endmodule

bind sreg_arbiter sreg_arbiter_chk #(.BANK_W(BANK_W), .FLAG_W(FLAG_W)) u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .flag_aff_i (flag_aff_i),
    .flag_val_i (flag_val_i),
    .wdt_clr_i  (wdt_clr_i),
    .sleep_i    (sleep_i),
    .wdt_to_i   (wdt_to_i),
    .status_o   (status_o)
);

// File: tb/sreg_arbiter_tb.sv
module sreg_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [2:0] flag_aff_i = 3'b000;
    logic [2:0] flag_val_i = 3'b000;
    logic       wdt_clr_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       wdt_to_i = 1'b0;
    logic [7:0] status_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference state
    int  m_bank;
    bit  m_to, m_pd;
    bit  m_z, m_dc, m_c;

    always #4 clk = ~clk;

    sreg_arbiter dut_i (
        .clk        (clk),
        .por_i      (por_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .flag_aff_i (flag_aff_i),
        .flag_val_i (flag_val_i),
        .wdt_clr_i  (wdt_clr_i),
        .sleep_i    (sleep_i),
        .wdt_to_i   (wdt_to_i),
        .status_o   (status_o)
    );

    function automatic logic [7:0] expect_word();
        logic [7:0] w;
        w[7:5] = m_bank[2:0];
        w[4] = m_to;  w[3] = m_pd;
        w[2] = m_z;   w[1] = m_dc;  w[0] = m_c;
        return w;
    endfunction

    task automatic check(input string tag);
        logic [7:0] exp;
        exp = expect_word();
        checks++;
        if (status_o !== exp) begin
            fails++;
            $display("FAIL %s: status_o=%b expected=%b at %0t", tag, status_o, exp, $time);
        end
    endtask

    task automatic cyc(input bit por, input bit wr, input logic [7:0] d,
                       input logic [2:0] aff, input logic [2:0] val,
                       input bit clr, input bit slp, input bit tmo, input string tag);
        @(negedge clk);
        por_i = por; wr_en_i = wr; wr_data_i = d;
        flag_aff_i = aff; flag_val_i = val;
        wdt_clr_i = clr; sleep_i = slp; wdt_to_i = tmo;
        @(posedge clk);
        if (por) begin
            m_bank = 0; m_to = 1; m_pd = 1; m_z = 0; m_dc = 0; m_c = 0;
        end else begin
            if (wr) m_bank = int'(d[7:5]);
            if (tmo)      m_to = 0;
            else if (slp) begin m_to = 1; m_pd = 0; end
            else if (clr) begin m_to = 1; m_pd = 1; end
            if (aff[2]) m_z = val[2];   else if (wr && aff == 3'b000) m_z = d[2];
            if (aff[1]) m_dc = val[1];  else if (wr && aff == 3'b000) m_dc = d[1];
            if (aff[0]) m_c = val[0];   else if (wr && aff == 3'b000) m_c = d[0];
        end
        #2;
        check(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(1, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R2 reset");
        cyc(1, 1, 8'hFF, 3'b111, 3'b111, 1, 1, 1, "R2 reset overrides");
        cyc(0, 1, 8'hFF, 3'b000, 3'b000, 0, 0, 0, "R3 R8 R9 full write");
        cyc(0, 1, 8'h00, 3'b100, 3'b100, 0, 0, 0, "R11 clear instruction");
        cyc(0, 1, 8'hA7, 3'b011, 3'b010, 0, 0, 0, "R8 blocked write");
        cyc(0, 0, 8'h55, 3'b000, 3'b000, 0, 0, 0, "R10 R9 idle hold");
        cyc(0, 0, 8'h00, 3'b101, 3'b001, 0, 0, 0, "R7 flag update");
        cyc(0, 1, 8'hE5, 3'b000, 3'b111, 0, 0, 0, "R1 layout write");
        cyc(0, 0, 8'h00, 3'b000, 3'b000, 0, 1, 0, "R4 sleep");
        cyc(0, 0, 8'h00, 3'b000, 3'b000, 0, 0, 1, "R6 timeout asleep");
        cyc(0, 0, 8'h00, 3'b000, 3'b000, 0, 0, 1, "R6 timeout repeat");
        cyc(0, 0, 8'h00, 3'b000, 3'b000, 1, 0, 0, "R5 watchdog clear");
        cyc(0, 0, 8'h00, 3'b000, 3'b000, 0, 0, 1, "R6 timeout awake");
        cyc(0, 1, 8'h18, 3'b000, 3'b000, 0, 0, 0, "R3 write power bits");
        cyc(0, 0, 8'h00, 3'b000, 3'b000, 1, 1, 0, "R4 sleep over clear");
        cyc(0, 1, 8'h08, 3'b000, 3'b000, 1, 0, 1, "R6 R3 timeout priority");
        cyc(0, 1, 8'hFF, 3'b000, 3'b000, 1, 0, 0, "R5 R3 clear with write");
        cyc(0, 1, 8'h07, 3'b111, 3'b000, 0, 0, 0, "R7 flags beat write");
        cyc(0, 1, 8'h00, 3'b100, 3'b100, 0, 1, 0, "R11 clear during sleep");
        for (int k = 0; k < 400; k++) begin
            logic [7:0] d;
            logic [2:0] a, v;
            logic [3:0] e;
            d = 8'($urandom); a = 3'($urandom); v = 3'($urandom); e = 4'($urandom);
            if (k % 3 == 0) a = 3'b000;
            cyc((k % 97) == 96, bit'($urandom_range(0, 1)), d, a, v,
                e[0], e[1] & e[2], e[3] & e[2], "R1 R7 R8 mixed");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule